// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer

This block is the digital core of a direct digital synthesizer. A 10-bit phase register adds a frequency control word on every clock and wraps modulo 1024. The phase is scaled onto a 100-entry sine table. That table holds offset-binary samples from 0 to 200, centred on 100. The block drives a registered 8-bit amplitude code to a converter downstream.

The output frequency is `fcw × f_clk / 1024`. With a 1 MHz clock, a control word of 128 gives a 125 kHz tone of eight samples per period. Control words from about 10 up to 256 cover roughly 10 kHz to 250 kHz. The control word can change at any time. The phase keeps its value through such a change, so the waveform has no discontinuity.

Top module: `dds_sine_synth`

## Requirements
- R1: The phase output is 10 bits wide. On each rising clock edge it becomes (phase + fcw) mod 1024. A control word of 1023 therefore steps the phase down by one.
- R2: While rst_ni is low, the block holds phase 0 and amplitude 100. Asserting rst_ni takes effect at once, without waiting for a clock edge.
- R3: The table index is floor(phase × 100 / 1024) and always lies in 0..99. For example, phase 1023 maps to index 99 and phase 1013 maps to index 98.
- R4: Table entry k is 100 + 100·sin(2πk/100), rounded to the nearest integer. Every entry lies in 0..200. Phase 0 gives 100, phase 256 gives 200, phase 512 gives 100 and phase 768 gives 0.
- R5: The amplitude is registered. After each edge it equals the table entry for the phase that was present before that edge.
- R6: A new control word is used from the next edge onward, and the phase is not reset when the word changes.
- R7: A control word of 0 holds the phase. From one edge later, the amplitude also stays constant.
- R8: With a control word of 128 after reset, the phase steps through 128, 256, …, 896, 0. The amplitudes that follow are 100, 168, 200, 173, 100, 32, 0, 27 and then repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcw_i | input | 10 | Frequency control word (phase step per clock) |
| phase_o | output | 10 | Current accumulator phase |
| amp_o | output | 8 | Registered sine amplitude code, 0..200 |

## Verification
The hardest states to reach are the top table entries near index 99 and the exact wrap across 1023→0. Ordinary control words rarely land there, and they land on different indices each period. To reach them, the stimulus parks the phase with a control word of 1023, which steps the phase backwards from 0 to 1023, 1022 and so on. It then holds the phase with a control word of 0 and reads back the index-99 and index-98 amplitudes. A long walk follows in which the control word changes often. Every edge of that walk is compared against an independent model of the accumulator and the table.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W = 10;
  localparam int TBL_N   = 100;
  localparam int AMP_W   = 8;
  localparam int AMP_MID = 100;
  localparam int QTR_N   = TBL_N / 4;
  localparam int IDX_W   = $clog2(TBL_N);

  // first quarter of round(100 + 100*sin(2*pi*k/100)), k = 0..25
  function automatic int qtr_sine(input int k);
    case (k)
      0: return 100;   1: return 106;   2: return 113;   3: return 119;
      4: return 125;   5: return 131;   6: return 137;   7: return 143;
      8: return 148;   9: return 154;  10: return 159;  11: return 164;
     12: return 168;  13: return 173;  14: return 177;  15: return 181;
     16: return 184;  17: return 188;  18: return 190;  19: return 193;
     20: return 195;  21: return 197;  22: return 198;  23: return 199;
     default: return 200;
    endcase
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = dds_pkg::PHASE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= phase_o + fcw_i;  // natural modulo 2^PHASE_W
  end
endmodule

// File: rtl/dds_phase_scale.sv
module dds_phase_scale #(
  parameter int PHASE_W = dds_pkg::PHASE_W,
  parameter int TBL_N   = dds_pkg::TBL_N,
  parameter int IDX_W   = $clog2(TBL_N)
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int PROD_W = PHASE_W + IDX_W;

  // floor(phase * N / 2^PHASE_W): constant multiply then shift
  always_comb idx_o = IDX_W'((PROD_W'(phase_i) * PROD_W'(TBL_N)) >> PHASE_W);
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int TBL_N   = dds_pkg::TBL_N,
  parameter int IDX_W   = $clog2(TBL_N),
  parameter int AMP_W   = dds_pkg::AMP_W,
  parameter int AMP_MID = dds_pkg::AMP_MID
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [AMP_W-1:0] amp_o
);
  localparam int Q = TBL_N / 4;

  int k, v;
  // quarter-wave store, mirrored in index and amplitude
  always_comb begin
    k = int'(idx_i);
    if (k <= Q)            v = dds_pkg::qtr_sine(k);
    else if (k <= 2 * Q)   v = dds_pkg::qtr_sine(2 * Q - k);
    else if (k <= 3 * Q)   v = 2 * AMP_MID - dds_pkg::qtr_sine(k - 2 * Q);
    else                   v = 2 * AMP_MID - dds_pkg::qtr_sine(4 * Q - k);
    amp_o = AMP_W'(v);
  end
endmodule

// File: rtl/dds_sine_synth.sv
module dds_sine_synth #(
  parameter int PHASE_W = dds_pkg::PHASE_W,
  parameter int TBL_N   = dds_pkg::TBL_N,
  parameter int AMP_W   = dds_pkg::AMP_W,
  parameter int AMP_MID = dds_pkg::AMP_MID
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o
);
  localparam int IDX_W = $clog2(TBL_N);

  logic [PHASE_W-1:0] phase_q;
  logic [IDX_W-1:0]   idx;
  logic [AMP_W-1:0]   amp_d;
  logic [AMP_W-1:0]   amp_q;

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fcw_i  (fcw_i),
    .phase_o(phase_q)
  );

  dds_phase_scale #(.PHASE_W(PHASE_W), .TBL_N(TBL_N), .IDX_W(IDX_W)) u_scale (
    .phase_i(phase_q),
    .idx_o  (idx)
  );

  dds_sine_rom #(.TBL_N(TBL_N), .IDX_W(IDX_W), .AMP_W(AMP_W), .AMP_MID(AMP_MID)) u_rom (
    .idx_i(idx),
    .amp_o(amp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= AMP_W'(AMP_MID);
    else         amp_q <= amp_d;
  end

  assign phase_o = phase_q;
  assign amp_o   = amp_q;

  a_r1_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_q == PHASE_W'($past(phase_q) + $past(fcw_i)));

  a_r2_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (phase_o == '0 && amp_o == AMP_W'(AMP_MID)));

  a_r3_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx) < TBL_N);

  a_r4_amp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(amp_q) <= 2 * AMP_MID);

  a_r7_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcw_i == '0 |=> $stable(phase_o));
endmodule

// File: tb/dds_sine_synth_test.sv
`timescale 1ns/1ps
module dds_sine_synth_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] fcw_i = '0;
  logic [9:0] phase_o;
  logic [7:0] amp_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_phase = 0;
  int m_amp = 100;

  // {expected phase, expected amp} per edge with fcw = 128 after reset
  localparam logic [17:0] VEC [8] = '{
    {10'd128, 8'd100}, {10'd256, 8'd168}, {10'd384, 8'd200}, {10'd512, 8'd173},
    {10'd640, 8'd100}, {10'd768, 8'd32},  {10'd896, 8'd0},   {10'd0,   8'd27}
  };

  always #2.5 clk_i = ~clk_i;

  dds_sine_synth uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fcw_i  (fcw_i),
    .phase_o(phase_o),
    .amp_o  (amp_o)
  );

  function automatic int tbl(input int p);
    int k;
    k = (p * 100) / 1024;
    return $rtoi(100.0 + 100.0 * $sin(2.0 * 3.14159265358979 * k / 100.0) + 0.5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one edge; model updated from pre-edge state, outputs sampled 1 ns later
  task automatic step(input string req);
    @(posedge clk_i);
    #1;
    m_amp   = tbl(m_phase);
    m_phase = (m_phase + int'(fcw_i)) % 1024;
    chk({req, " phase"}, int'(phase_o), m_phase);
    chk({req, " amp"}, int'(amp_o), m_amp);
  endtask

  task automatic do_reset();
    #1;
    rst_ni = 1'b0;
    #1;
    chk("R2 async phase", int'(phase_o), 0);
    chk("R2 async amp", int'(amp_o), 100);
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    m_phase = 0;
    m_amp = 100;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R2 reset phase", int'(phase_o), 0);
    chk("R2 reset amp", int'(amp_o), 100);
    rst_ni = 1'b1;

    // R8 vector walk, two full periods
    fcw_i = 10'd128;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk_i);
      #1;
      chk("R8 phase", int'(phase_o), int'(VEC[i % 8][17:8]));
      chk("R8 amp", int'(amp_o), int'(VEC[i % 8][7:0]));
    end
    // R4 landmark values: quarter steps from phase 0
    do_reset();
    fcw_i = 10'd256;
    for (int i = 0; i < 5; i++) step("R4 quarter");

    // R1/R3 wrap backwards to 1023, index 99 and 98
    do_reset();
    fcw_i = 10'd1023;
    step("R1 wrap");
    chk("R1 wrap to 1023", int'(phase_o), 1023);
    fcw_i = 10'd0;
    step("R3 idx99");
    chk("R3 idx99 amp", int'(amp_o), 94);
    fcw_i = 10'd1013 - 10'd1023;
    step("R3 step to 1013");
    fcw_i = 10'd0;
    step("R3 idx98");
    chk("R3 idx98 amp", int'(amp_o), 87);

    // R7 zero control word holds phase and amplitude
    fcw_i = 10'd77;
    step("R7 prep");
    fcw_i = 10'd0;
    step("R7 first");
    for (int i = 0; i < 4; i++) begin
      logic [9:0] p;
      logic [7:0] a;
      p = phase_o;
      a = amp_o;
      step("R7 hold");
      chk("R7 phase stable", int'(phase_o), int'(p));
      chk("R7 amp stable", int'(amp_o), int'(a));
    end

    // R6/R5 changing control word, phase kept across changes
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fcw_i = lfsr[9:0];
      end
      step("R6 R5 walk");
    end

    // R2 reset mid-run, then resume
    do_reset();
    fcw_i = 10'd300;
    for (int i = 0; i < 6; i++) step("R2 resume");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule